// File: doc/BRIEF.md
# Time-Slot Scheduled Mesh Crossbar

This block sits in one tile of a two-dimensional array of processing elements. It moves 32-bit words between four mesh neighbours (north, south, east, west) and the tile's own core. Nothing is arbitrated and there is no flow control. A schedule memory holds one configuration per time slot. A free-running slot counter steps through the configured entries and then starts again at slot 0. One full pass is the frame that makes up one user clock cycle. Each configuration names, for every output, which input feeds it in that slot.

When two transfers would collide, the offline scheduler can park a word in a small hold buffer and forward it in a later slot. Each schedule entry carries one hold-buffer write (the source input and the address) and one hold-buffer read address. Every output may select the hold buffer as its source. Any number of outputs may select the same source in a slot, so one input can be copied to several outputs.

The schedule and the frame length are loaded only while reset is asserted. After reset is released the block just replays the schedule.

Top module: `sched_mesh_router`

## Requirements
- R1: While rst is high, and in the first cycle after it falls, every out_valid bit is 0, every out_word is 0 and slot_idx is 0.
- R2: slot_idx counts 0, 1, ..., P-1 and then returns to 0, advancing once per clock. P is sampled from frame_len while rst is high. A frame_len of 0 is treated as 1, and a value above 64 is treated as 64.
- R3: frame_start is 1 exactly in the cycles where slot_idx equals P-1 (always 1 when P is 1), including during reset.
- R4: Entry bits [3k+2:3k] select the source of output k (k: 0 north, 1 south, 2 east, 3 west, 4 core). Select codes 0 to 4 name the input with that same index. If output k selects such an input in slot s, then in the next cycle out_word[k] and out_valid[k] equal that input's word and valid as driven during slot s.
- R5: Select codes 6 and 7 make the output idle: in the next cycle its word is 0 and its valid is 0.
- R6: Entry bits [17:15] name a hold-write source (codes 0 to 4 as in R4; codes 5 to 7 mean no write). Bits [19:18] give the write address. At the end of the slot, the source's word and valid are stored at that hold address.
- R7: Select code 5 forwards the hold entry addressed by bits [21:20]. A write made in the same slot is not visible to that read; it is visible from the next slot on.
- R8: Schedule loads (ld_en, ld_addr, ld_entry) are accepted only while rst is high. A load attempted while running leaves the schedule unchanged.
- R9: Reset clears all four hold entries to word 0 with valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_len | input | 7 | Frame length in slots, sampled during reset |
| ld_en | input | 1 | Schedule write strobe (honoured only in reset) |
| ld_addr | input | 6 | Schedule slot to write |
| ld_entry | input | 22 | Schedule entry to write |
| in_word | input | 5x32 | Input words, index 0 N, 1 S, 2 E, 3 W, 4 core |
| in_valid | input | 5 | Input valid flags, same indexing |
| out_word | output | 5x32 | Registered output words |
| out_valid | output | 5 | Registered output valid flags |
| slot_idx | output | 6 | Current time slot |
| frame_start | output | 1 | High in the last slot of a frame |

## Verification
Two functions can meet in one slot: the hold buffer can be written and read at the same address. The bench builds a slot whose entry writes the east input into hold address 1 while an output reads address 1. That output must show the value from before the write, which is the cleared entry after reset. The following slot reads the same address and must show the east word. Random schedules also produce this overlap many times, and a reference model that applies reads before writes judges each case.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int NPORT = 5;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_N    = 3'd0,
    SRC_S    = 3'd1,
    SRC_E    = 3'd2,
    SRC_W    = 3'd3,
    SRC_CORE = 3'd4,
    SRC_HOLD = 3'd5,
    SRC_OFF0 = 3'd6,
    SRC_OFF1 = 3'd7
  } src_e;

  // Entry layout: per-output selects, then hold write source, write addr, read addr
  localparam int HWS_LO = NPORT * SEL_W;
  localparam int HWA_LO = HWS_LO + SEL_W;
endpackage

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
  parameter int MAX_SLOTS = 64,
  localparam int SLOT_W = $clog2(MAX_SLOTS),
  localparam int LEN_W  = $clog2(MAX_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  frame_len,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] slot_nxt,
  output logic              last_q
);
  logic [LEN_W-1:0] len_c;
  logic [LEN_W-1:0] period_q;

  always_comb begin
    if (frame_len == '0)
      len_c = LEN_W'(1);
    else if (frame_len > LEN_W'(MAX_SLOTS))
      len_c = LEN_W'(MAX_SLOTS);
    else
      len_c = frame_len;
  end

  always_comb begin
    if (rst || last_q)
      slot_nxt = '0;
    else
      slot_nxt = slot_q + SLOT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= len_c;
      slot_q   <= '0;
      last_q   <= (len_c == LEN_W'(1));
    end else begin
      slot_q   <= slot_nxt;
      last_q   <= (LEN_W'(slot_nxt) == period_q - LEN_W'(1));
    end
  end

  // R2: slot stays inside the programmed frame
  a_r2_slot_in_frame: assert property (@(posedge clk) disable iff (rst)
    LEN_W'(slot_q) < period_q);

  // R2: slot advances by one when not at the end of the frame
  a_r2_slot_step: assert property (@(posedge clk) disable iff (rst)
    !last_q |=> slot_q == $past(slot_q) + SLOT_W'(1));

  // R3: after the last slot the frame restarts at zero
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    last_q |=> slot_q == '0);
endmodule

// File: rtl/sched_store.sv
module sched_store #(
  parameter int DEPTH = 64,
  parameter int W     = 22,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [W-1:0]  ld_entry,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_entry
);
  logic [W-1:0] mem [DEPTH];

  // Simple dual-port RAM with a registered read port
  always_ff @(posedge clk) begin
    if (rst && ld_en)
      mem[ld_addr] <= ld_entry;
    rd_entry <= mem[rd_addr];
  end

  // R8: a load that arrives while running must not disturb the read port
  a_r8_run_read_stable: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_addr == rd_addr && $past(rd_addr) == rd_addr && !$past(rst))
      |=> rd_entry == $past(rd_entry));
endmodule

// File: rtl/hold_store.sv
module hold_store #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_word,
  input  logic          wr_valid,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_word,
  output logic          rd_valid
);
  logic [W-1:0] word_q  [DEPTH];
  logic         valid_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        word_q[i]  <= '0;
        valid_q[i] <= 1'b0;
      end
    end else if (wr_en) begin
      word_q[wr_addr]  <= wr_word;
      valid_q[wr_addr] <= wr_valid;
    end
  end

  // Read returns the contents before any write of the current slot
  assign rd_word  = word_q[rd_addr];
  assign rd_valid = valid_q[rd_addr];

  // R6: a parked word is available at its address from the next slot
  a_r6_park_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> word_q[$past(wr_addr)] == $past(wr_word)
           && valid_q[$past(wr_addr)] == $past(wr_valid));
endmodule

// File: rtl/xbar_stage.sv
module xbar_stage
  import router_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPORT-1:0][SEL_W-1:0]  sel,
  input  logic [NPORT-1:0][W-1:0]      in_word,
  input  logic [NPORT-1:0]             in_valid,
  input  logic [W-1:0]                 hold_word,
  input  logic                         hold_valid,
  output logic [NPORT-1:0][W-1:0]      out_word,
  output logic [NPORT-1:0]             out_valid
);
  logic [NPORT-1:0][W-1:0] nxt_word;
  logic [NPORT-1:0]        nxt_valid;

  always_comb begin
    for (int k = 0; k < NPORT; k++) begin
      nxt_word[k]  = '0;
      nxt_valid[k] = 1'b0;
      if (sel[k] < SEL_W'(NPORT)) begin
        nxt_word[k]  = in_word[sel[k]];
        nxt_valid[k] = in_valid[sel[k]];
      end else if (sel[k] == SRC_HOLD) begin
        nxt_word[k]  = hold_word;
        nxt_valid[k] = hold_valid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word  <= '0;
      out_valid <= '0;
    end else begin
      out_word  <= nxt_word;
      out_valid <= nxt_valid;
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_chk
    // R4: a selected input appears on the output one cycle later
    a_r4_pass_through: assert property (@(posedge clk) disable iff (rst)
      (sel[g] < SEL_W'(NPORT)) |=> out_word[g] == $past(in_word[sel[g]])
                                 && out_valid[g] == $past(in_valid[sel[g]]));
    // R5: an idle select drives zero with valid low
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      (sel[g] == SRC_OFF0 || sel[g] == SRC_OFF1) |=> !out_valid[g] && out_word[g] == '0);
  end
endmodule

// File: rtl/sched_mesh_router.sv
module sched_mesh_router
  import router_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MAX_SLOTS  = 64,
  parameter int HOLD_DEPTH = 4,
  localparam int SLOT_W  = $clog2(MAX_SLOTS),
  localparam int LEN_W   = $clog2(MAX_SLOTS + 1),
  localparam int HOLD_AW = $clog2(HOLD_DEPTH),
  localparam int ENTRY_W = HWA_LO + 2 * HOLD_AW
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LEN_W-1:0]              frame_len,
  input  logic                          ld_en,
  input  logic [SLOT_W-1:0]             ld_addr,
  input  logic [ENTRY_W-1:0]            ld_entry,
  input  logic [NPORT-1:0][DATA_W-1:0]  in_word,
  input  logic [NPORT-1:0]              in_valid,
  output logic [NPORT-1:0][DATA_W-1:0]  out_word,
  output logic [NPORT-1:0]              out_valid,
  output logic [SLOT_W-1:0]             slot_idx,
  output logic                          frame_start
);
  localparam int HRA_LO = HWA_LO + HOLD_AW;

  logic [SLOT_W-1:0]            slot_nxt;
  logic [ENTRY_W-1:0]           cur_entry;
  logic [NPORT-1:0][SEL_W-1:0]  out_sel;
  logic [SEL_W-1:0]             park_src;
  logic                         park_en;
  logic [DATA_W-1:0]            park_word;
  logic                         park_valid;
  logic [HOLD_AW-1:0]           park_addr;
  logic [HOLD_AW-1:0]           fetch_addr;
  logic [DATA_W-1:0]            fetch_word;
  logic                         fetch_valid;

  slot_sequencer #(.MAX_SLOTS(MAX_SLOTS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .frame_len (frame_len),
    .slot_q    (slot_idx),
    .slot_nxt  (slot_nxt),
    .last_q    (frame_start)
  );

  // Read address runs one slot ahead so the registered entry matches slot_idx
  sched_store #(.DEPTH(MAX_SLOTS), .W(ENTRY_W)) u_sched (
    .clk      (clk),
    .rst      (rst),
    .ld_en    (ld_en),
    .ld_addr  (ld_addr),
    .ld_entry (ld_entry),
    .rd_addr  (slot_nxt),
    .rd_entry (cur_entry)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_sel
    assign out_sel[g] = cur_entry[g*SEL_W +: SEL_W];
  end

  assign park_src   = cur_entry[HWS_LO +: SEL_W];
  assign park_addr  = cur_entry[HWA_LO +: HOLD_AW];
  assign fetch_addr = cur_entry[HRA_LO +: HOLD_AW];
  assign park_en    = park_src < SEL_W'(NPORT);

  always_comb begin
    park_word  = '0;
    park_valid = 1'b0;
    if (park_en) begin
      park_word  = in_word[park_src];
      park_valid = in_valid[park_src];
    end
  end

  hold_store #(.DEPTH(HOLD_DEPTH), .W(DATA_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (park_en),
    .wr_addr  (park_addr),
    .wr_word  (park_word),
    .wr_valid (park_valid),
    .rd_addr  (fetch_addr),
    .rd_word  (fetch_word),
    .rd_valid (fetch_valid)
  );

  xbar_stage #(.W(DATA_W)) u_xbar (
    .clk        (clk),
    .rst        (rst),
    .sel        (out_sel),
    .in_word    (in_word),
    .in_valid   (in_valid),
    .hold_word  (fetch_word),
    .hold_valid (fetch_valid),
    .out_word   (out_word),
    .out_valid  (out_valid)
  );

  // R1: outputs are quiet in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> out_valid == '0 && slot_idx == '0);
endmodule

// File: tb/sched_mesh_router_test.sv
`timescale 1ns/1ps
module sched_mesh_router_test;
  localparam int DW = 32, NP = 5, MS = 64, HD = 4, EW = 22;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                    rst = 1'b1;
  logic [6:0]              frame_len = 7'd1;
  logic                    ld_en = 1'b0;
  logic [5:0]              ld_addr = '0;
  logic [EW-1:0]           ld_entry = '0;
  logic [NP-1:0][DW-1:0]   in_word = '0;
  logic [NP-1:0]           in_valid = '0;
  logic [NP-1:0][DW-1:0]   out_word;
  logic [NP-1:0]           out_valid;
  logic [5:0]              slot_idx;
  logic                    frame_start;

  sched_mesh_router uut (
    .clk(clk), .rst(rst), .frame_len(frame_len), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_entry(ld_entry), .in_word(in_word), .in_valid(in_valid), .out_word(out_word),
    .out_valid(out_valid), .slot_idx(slot_idx), .frame_start(frame_start)
  );

  int checks = 0, fails = 0;
  logic [EW-1:0] sch [MS];
  bit            poked [MS];
  logic [DW-1:0] hw [HD];
  logic          hv [HD];
  bit            hwritten [HD];
  logic [DW-1:0] ew [NP];
  logic          ev [NP];
  string         etag [NP];
  bit            have_exp = 0;
  int            ms = 0, plen = 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [EW-1:0] mk(input logic [2:0] s0, s1, s2, s3, s4, hws,
                                       input logic [1:0] wa, ra);
    return {ra, wa, hws, s4, s3, s2, s1, s0};
  endfunction

  function automatic int clamp_len(input int v);
    if (v == 0) return 1;
    if (v > MS) return MS;
    return v;
  endfunction

  task automatic check_now();
    chk("R2 slot", 64'(slot_idx), 64'(ms));
    chk("R3 frame_start", 64'(frame_start), 64'(ms == plen - 1));
    if (have_exp)
      for (int k = 0; k < NP; k++) begin
        chk(etag[k], {31'b0, out_valid[k], out_word[k]}, {31'b0, ev[k], ew[k]});
      end
  endtask

  task automatic do_reset(input int len);
    rst = 1'b1;
    frame_len = 7'(len);
    in_word = '0;
    in_valid = '0;
    plen = clamp_len(len);
    for (int s = 0; s < plen; s++) begin
      ld_en = 1'b1; ld_addr = 6'(s); ld_entry = sch[s]; poked[s] = 0;
      @(negedge clk);
    end
    ld_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    for (int k = 0; k < NP; k++) chk("R1 out_word", 64'(out_word[k]), 64'd0);
    for (int h = 0; h < HD; h++) begin
      hw[h] = '0; hv[h] = 1'b0; hwritten[h] = 0;
    end
    ms = 0;
    have_exp = 0;
  endtask

  // Called at a negedge: checks the previous slot, then drives this slot
  task automatic step(input logic [NP-1:0][DW-1:0] w, input logic [NP-1:0] v, input bit poke);
    logic [EW-1:0] e;
    logic [2:0] sl, hws;
    logic [1:0] wa, ra;
    check_now();
    rst = 1'b0;
    in_word = w;
    in_valid = v;
    ld_en = poke;
    if (poke) begin
      ld_addr = 6'(ms);
      ld_entry = ~sch[ms];
      poked[ms] = 1;
    end
    e = sch[ms];
    hws = e[17:15]; wa = e[19:18]; ra = e[21:20];
    for (int k = 0; k < NP; k++) begin
      sl = e[3*k +: 3];
      if (sl < 3'd5) begin
        ew[k] = w[sl]; ev[k] = v[sl]; etag[k] = "R4 pass";
      end else if (sl == 3'd5) begin
        ew[k] = hw[ra]; ev[k] = hv[ra];
        if (hws < 3'd5 && wa == ra) etag[k] = "R7 same-slot hold read";
        else if (hwritten[ra]) etag[k] = "R6 hold read of parked word";
        else etag[k] = "R9 cleared hold read";
      end else begin
        ew[k] = '0; ev[k] = 1'b0; etag[k] = "R5 idle";
      end
      if (poked[ms]) etag[k] = "R8 ignored load";
    end
    if (hws < 3'd5) begin
      hw[wa] = w[hws]; hv[wa] = v[hws]; hwritten[wa] = 1;
    end
    ms = (ms + 1) % plen;
    have_exp = 1;
    @(negedge clk);
  endtask

  task automatic rnd_step(input int pat, input bit poke);
    logic [NP-1:0][DW-1:0] w;
    logic [NP-1:0] v;
    for (int k = 0; k < NP; k++) begin
      case (pat)
        1: w[k] = (k % 2 == 0) ? 32'hFFFF_FFFF : 32'h0;
        2: w[k] = 32'hA000_0000 | 32'(k);
        default: w[k] = $urandom;
      endcase
    end
    v = (pat == 1) ? '1 : NP'($urandom);
    step(w, v, poke);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // Phase A: directed hold corner in slots 0 and 1, frame of 8
    for (int s = 0; s < MS; s++) sch[s] = EW'($urandom);
    // slot 0: park east at addr 1 and read addr 1 in the same slot (R7)
    sch[0] = mk(3'd5, 3'd2, 3'd4, 3'd6, 3'd0, 3'd2, 2'd1, 2'd1);
    // slot 1: west output reads addr 1, parked in slot 0 (R6); no write
    sch[1] = mk(3'd4, 3'd4, 3'd7, 3'd5, 3'd1, 3'd7, 2'd0, 2'd1);
    do_reset(8);
    for (int i = 0; i < 40; i++) rnd_step(i % 3, i == 10);
    // Phase B: frame_len 0 behaves as a single-slot frame
    sch[0] = mk(3'd3, 3'd2, 3'd5, 3'd6, 3'd4, 3'd0, 2'd2, 2'd2);
    do_reset(0);
    for (int i = 0; i < 20; i++) rnd_step(0, 0);
    // Phase C: frame_len above the maximum clamps to 64, random schedule
    for (int s = 0; s < MS; s++) sch[s] = EW'($urandom);
    do_reset(100);
    for (int i = 0; i < 300; i++) rnd_step(i % 5 == 0 ? 1 : 0, i == 70 || i == 200);
    // Phase D: short frame of 5
    for (int s = 0; s < 5; s++) sch[s] = EW'($urandom);
    do_reset(5);
    for (int i = 0; i < 60; i++) rnd_step(i % 3, 0);
    check_now();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule